// File: doc/BRIEF.md
# Secure-Gated Flash Bus Front End

This block sits between a system bus and a byte-addressed parallel NOR flash array. It serves single-beat reads and writes of 1, 2 or 4 bytes. Each of them carries a secure attribute, and each gets a one-bit response one cycle later. Read data is gathered from consecutive array bytes. A configuration bit sets the lane order: little-endian or big-endian.

Writes normally drive a small command machine. This machine selects what reads return: raw array data, a ready status or an identification word. It also arms a one-shot program operation. A program clears array bits only, as flash cells do.

A second configuration bit turns on secure-only operation. In that mode a read from a non-secure master always returns raw array contents and bypasses the command machine. A write from a non-secure master is discarded and answered with an error.

Top module: `flash_sec_front`

## Requirements
- R1: After reset no response is valid, the command machine is in array mode and every array byte reads 0xFF.
- R2: Every request with req_valid_i high produces rsp_valid_o high in exactly the next cycle, and only then. rsp_err_o is 0 for OK and 1 for error.
- R3: Only sizes 1, 2 and 4 are legal. Any other size gets an error response with rsp_rdata_o zero, and it changes neither the array nor the command mode.
- R4: With cfg_i[0]=0 (little-endian), the byte at address A+k of an n-byte read appears in rsp_rdata_o bits 8k+7:8k. Unused upper bits are zero.
- R5: With cfg_i[0]=1 (big-endian), the byte at the lowest address lands in the most significant byte of the n-byte value. For a 2-byte read that is bits 15:8.
- R6: Byte addresses of a multi-byte access wrap modulo DEPTH.
- R7: The command byte is wdata bits 7:0. A command write responds OK with zero data. The codes are:
  - 0xFF selects array mode.
  - 0x70 selects status mode, where reads return 0x00000080.
  - 0x90 selects identify mode, where reads return ID_CODE. Status and identify values are returned in full, whatever the read size.
  - 0x40 arms a program.
  - Any other code selects array mode.
- R8: The write that follows 0x40 is a program. It uses the same lane mapping as reads, and each addressed byte becomes old AND new. Afterwards the mode is status.
- R9: With cfg_i[1]=1, a non-secure legal read returns array data whatever the mode, and responds OK.
- R10: With cfg_i[1]=1, a non-secure write responds with an error and changes neither the array nor the mode.
- R11: Secure legal accesses, and all legal accesses while cfg_i[1]=0, use the command-aware path and respond OK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_i | input | 2 | Bit 0 big-endian, bit 1 secure-only |
| req_valid_i | input | 1 | Request strobe, one transaction per cycle |
| req_write_i | input | 1 | 1 write, 0 read |
| req_secure_i | input | 1 | Secure attribute of the master |
| req_size_i | input | 3 | Access size in bytes |
| req_addr_i | input | AW | Byte address |
| req_wdata_i | input | 32 | Write data, command byte in bits 7:0 |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| rsp_err_o | output | 1 | 0 OK, 1 error |
| rsp_rdata_o | output | 32 | Read data, zero for writes and errors |

## Verification
Fixed byte patterns such as 11 22 33 44 are read back at sizes 1, 2 and 4 under both lane orders. A swapped lane or a misplaced narrow read then shows up as a wrong value rather than a symmetric coincidence. Directed programs placed at the top of the array separate a correct address wrap from truncation. In mode-sensitive sequences, an array read is issued in identify mode under secure and non-secure attributes. This tells the bypass path apart from the command path. Non-secure write attempts are always followed by secure read-back, which proves they left the array and the mode untouched. A seeded random mix then exercises all of these together: commands, programs, illegal sizes and configuration changes.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;
  localparam int LANES = 4;
  localparam int CFG_BE_BIT = 0;
  localparam int CFG_SEC_BIT = 1;

  typedef enum logic [1:0] {
    MODE_ARRAY  = 2'd0,
    MODE_STATUS = 2'd1,
    MODE_ID     = 2'd2,
    MODE_PROG   = 2'd3
  } fe_mode_e;

  localparam logic [7:0] CMD_ARRAY    = 8'hFF;
  localparam logic [7:0] CMD_STATUS   = 8'h70;
  localparam logic [7:0] CMD_ID       = 8'h90;
  localparam logic [7:0] CMD_PROG     = 8'h40;
  localparam logic [7:0] STATUS_READY = 8'h80;
endpackage

// File: rtl/flash_lane_map.sv
module flash_lane_map
  import flash_fe_pkg::*;
(
  input  logic                    be_i,
  input  logic [2:0]              size_i,
  input  logic [LANES-1:0][7:0]   rd_bytes_i,
  input  logic [8*LANES-1:0]      wdata_i,
  output logic [8*LANES-1:0]      rdata_o,
  output logic [LANES-1:0][7:0]   wr_bytes_o
);
  int n;

  always_comb begin
    n = (size_i == 3'd1 || size_i == 3'd2 || size_i == 3'd4) ? int'(size_i) : 0;
    rdata_o = '0;
    wr_bytes_o = '0;
    for (int k = 0; k < LANES; k++) begin
      if (k < n) begin
        if (be_i) begin
          rdata_o[8*(n-1-k) +: 8] = rd_bytes_i[k];
          wr_bytes_o[k] = wdata_i[8*(n-1-k) +: 8];
        end else begin
          rdata_o[8*k +: 8] = rd_bytes_i[k];
          wr_bytes_o[k] = wdata_i[8*k +: 8];
        end
      end
    end
  end
endmodule

// File: rtl/flash_byte_array.sv
module flash_byte_array
  import flash_fe_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [AW-1:0]         addr_i,
  output logic [LANES-1:0][7:0] rd_bytes_o,
  input  logic                  prog_en_i,
  input  logic [2:0]            prog_size_i,
  input  logic [LANES-1:0][7:0] prog_bytes_i
);
  // DEPTH must be a power of two: lane addresses wrap through AW-bit truncation
  logic [7:0] mem_q [DEPTH];

  always_comb begin
    for (int k = 0; k < LANES; k++) rd_bytes_o[k] = mem_q[addr_i + AW'(k)];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (prog_en_i) begin
      for (int k = 0; k < LANES; k++) begin
        if (k < int'(prog_size_i))
          mem_q[addr_i + AW'(k)] <= mem_q[addr_i + AW'(k)] & prog_bytes_i[k];
      end
    end
  end

  AST_PROG_LEGAL_SIZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_en_i |-> (prog_size_i == 3'd1 || prog_size_i == 3'd2 || prog_size_i == 3'd4)); // R3
endmodule

// File: rtl/flash_cmd_stub.sv
module flash_cmd_stub
  import flash_fe_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wr_en_i,
  input  logic [7:0] cmd_i,
  output fe_mode_e mode_o,
  output logic     prog_o
);
  fe_mode_e mode_q, mode_d;

  assign mode_o = mode_q;
  assign prog_o = wr_en_i && (mode_q == MODE_PROG);

  always_comb begin
    mode_d = mode_q;
    if (wr_en_i) begin
      if (mode_q == MODE_PROG) mode_d = MODE_STATUS;
      else begin
        unique case (cmd_i)
          CMD_STATUS: mode_d = MODE_STATUS;
          CMD_ID:     mode_d = MODE_ID;
          CMD_PROG:   mode_d = MODE_PROG;
          default:    mode_d = MODE_ARRAY;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_ARRAY;
    else         mode_q <= mode_d;
  end

  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(mode_o)); // R10
  AST_PROG_TO_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && mode_o == MODE_PROG) |=> mode_o == MODE_STATUS); // R8
endmodule

// File: rtl/flash_sec_front.sv
module flash_sec_front
  import flash_fe_pkg::*;
#(
  parameter int          DEPTH   = 64,
  parameter logic [31:0] ID_CODE = 32'h0000_0089,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    cfg_i,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic          req_secure_i,
  input  logic [2:0]    req_size_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [31:0]   req_wdata_i,
  output logic          rsp_valid_o,
  output logic          rsp_err_o,
  output logic [31:0]   rsp_rdata_o
);
  logic size_ok, ns_block, acc_ok, wr_go, prog_go;
  fe_mode_e mode;
  logic [LANES-1:0][7:0] arr_bytes, wr_bytes;
  logic [31:0] arr_word, rd_val;

  assign size_ok  = (req_size_i == 3'd1) || (req_size_i == 3'd2) || (req_size_i == 3'd4);
  assign ns_block = cfg_i[CFG_SEC_BIT] & ~req_secure_i;
  assign acc_ok   = req_valid_i & size_ok & ~(req_write_i & ns_block);
  assign wr_go    = acc_ok & req_write_i;

  flash_cmd_stub u_cmd (
    .clk_i, .rst_ni,
    .wr_en_i (wr_go),
    .cmd_i   (req_wdata_i[7:0]),
    .mode_o  (mode),
    .prog_o  (prog_go)
  );

  flash_lane_map u_lanes (
    .be_i       (cfg_i[CFG_BE_BIT]),
    .size_i     (req_size_i),
    .rd_bytes_i (arr_bytes),
    .wdata_i    (req_wdata_i),
    .rdata_o    (arr_word),
    .wr_bytes_o (wr_bytes)
  );

  flash_byte_array #(.DEPTH(DEPTH)) u_array (
    .clk_i, .rst_ni,
    .addr_i       (req_addr_i),
    .rd_bytes_o   (arr_bytes),
    .prog_en_i    (prog_go),
    .prog_size_i  (req_size_i),
    .prog_bytes_i (wr_bytes)
  );

  // non-secure reads in secure-only mode bypass the command path
  always_comb begin
    if (ns_block || mode == MODE_ARRAY) rd_val = arr_word;
    else if (mode == MODE_ID)           rd_val = ID_CODE;
    else                                rd_val = {24'h0, STATUS_READY};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_err_o   <= req_valid_i & ~acc_ok;
      rsp_rdata_o <= (acc_ok & ~req_write_i) ? rd_val : '0;
    end
  end

  AST_RSP_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o); // R2
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o); // R2
  AST_BAD_SIZE_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_size_i != 3'd1 && req_size_i != 3'd2 && req_size_i != 3'd4)
      |=> rsp_err_o); // R3
  AST_ERR_NO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> rsp_rdata_o == 32'h0); // R3
  AST_NS_WRITE_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && cfg_i[1] && !req_secure_i) |=> rsp_err_o); // R10
  AST_NS_READ_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i && cfg_i[1] && !req_secure_i && size_ok) |=> !rsp_err_o); // R9
  AST_SECURE_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && size_ok && (req_secure_i || !cfg_i[1])) |=> !rsp_err_o); // R11
endmodule

// File: tb/flash_sec_front_bench.sv
module flash_sec_front_bench;
  localparam int DEPTH = 64;
  localparam logic [31:0] IDC = 32'h0000_0089;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cfg = 2'b00;
  logic req_valid = 1'b0, req_write = 1'b0, req_secure = 1'b0;
  logic [2:0] req_size = 3'd1;
  logic [5:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;

  int checks = 0, errors = 0;
  logic [7:0] m_mem [DEPTH];
  int m_mode = 0; // 0 array, 1 status, 2 id, 3 prog

  always #4 clk = ~clk;

  flash_sec_front #(.DEPTH(DEPTH), .ID_CODE(IDC)) u_flash_sec_front (
    .clk_i(clk), .rst_ni(rst_n), .cfg_i(cfg),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_secure_i(req_secure),
    .req_size_i(req_size), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rsp_rdata_o(rsp_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pack(input int addr, input int size, input bit be);
    logic [31:0] v = '0;
    for (int k = 0; k < size; k++) begin
      if (be) v[8*(size-1-k) +: 8] = m_mem[(addr + k) % DEPTH];
      else    v[8*k +: 8]          = m_mem[(addr + k) % DEPTH];
    end
    return v;
  endfunction

  task automatic txn(input bit wr, input int addr, input int size, input bit sec,
                     input logic [31:0] wd, input logic [1:0] c, input string tag);
    bit legal, nsb, e_err;
    logic [31:0] e_data;
    logic [7:0] b;
    legal = (size == 1 || size == 2 || size == 4);
    nsb = c[1] && !sec;
    e_err = !legal || (wr && nsb);
    e_data = '0;
    if (!e_err && !wr) begin
      if (nsb || m_mode == 0) e_data = pack(addr, size, c[0]);
      else if (m_mode == 2)   e_data = IDC;
      else                    e_data = 32'h80;
    end
    if (!e_err && wr) begin
      if (m_mode == 3) begin
        for (int k = 0; k < size; k++) begin
          b = c[0] ? wd[8*(size-1-k) +: 8] : wd[8*k +: 8];
          m_mem[(addr + k) % DEPTH] = m_mem[(addr + k) % DEPTH] & b;
        end
        m_mode = 1;
      end else begin
        case (wd[7:0])
          8'h70: m_mode = 1;
          8'h90: m_mode = 2;
          8'h40: m_mode = 3;
          default: m_mode = 0;
        endcase
      end
    end
    @(negedge clk);
    cfg = c; req_valid = 1'b1; req_write = wr; req_secure = sec;
    req_size = 3'(size); req_addr = 6'(addr); req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " valid"}, 32'(rsp_valid), 32'd1);
    chk({tag, " err"}, 32'(rsp_err), 32'(e_err));
    chk({tag, " data"}, rsp_rdata, e_data);
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 no response after reset", 32'(rsp_valid), 32'd0);
    txn(0, 0, 4, 1, 0, 2'b00, "R1 erased read");
    // program 11 22 33 44 at 0, little-endian
    txn(1, 0, 1, 1, 32'h40, 2'b00, "R7 program arm");
    txn(1, 0, 4, 1, 32'h44332211, 2'b00, "R8 program word");
    txn(0, 0, 4, 1, 0, 2'b00, "R8 status after program");
    txn(1, 0, 1, 1, 32'hFF, 2'b00, "R7 array cmd");
    txn(0, 0, 4, 1, 0, 2'b00, "R4 le word");
    txn(0, 0, 2, 1, 0, 2'b00, "R4 le half");
    txn(0, 3, 1, 1, 0, 2'b00, "R4 byte");
    txn(0, 0, 4, 1, 0, 2'b01, "R5 be word");
    txn(0, 0, 2, 1, 0, 2'b01, "R5 be half");
    txn(0, 1, 2, 1, 0, 2'b01, "R5 be half odd");
    @(negedge clk);
    chk("R2 idle no response", 32'(rsp_valid), 32'd0);
    // wrap at top, big-endian program
    txn(1, 0, 1, 1, 32'h40, 2'b01, "R7 arm be");
    txn(1, 62, 4, 1, 32'hA1B2C3D4, 2'b01, "R6 wrap program");
    txn(1, 0, 1, 1, 32'hFF, 2'b01, "R7 array");
    txn(0, 62, 4, 1, 0, 2'b00, "R6 wrap read");
    txn(0, 0, 4, 1, 0, 2'b00, "R6 low bytes");
    // illegal sizes
    txn(0, 0, 3, 1, 0, 2'b00, "R3 size3 read");
    txn(1, 0, 0, 1, 32'h90, 2'b00, "R3 size0 cmd");
    txn(0, 0, 4, 1, 0, 2'b00, "R3 mode unchanged");
    txn(1, 0, 5, 1, 32'h40, 2'b00, "R3 size5 write");
    // identify and secure-only
    txn(1, 0, 1, 1, 32'h90, 2'b00, "R7 id cmd");
    txn(0, 0, 1, 1, 0, 2'b00, "R7 id read");
    txn(0, 0, 4, 0, 0, 2'b10, "R9 ns bypass");
    txn(0, 0, 2, 0, 0, 2'b11, "R9 ns bypass be");
    txn(0, 0, 4, 1, 0, 2'b10, "R11 secure id");
    txn(1, 0, 1, 0, 32'hFF, 2'b10, "R10 ns cmd");
    txn(0, 0, 4, 1, 0, 2'b10, "R10 mode kept");
    txn(1, 0, 1, 1, 32'h40, 2'b10, "R11 secure arm");
    txn(1, 0, 4, 0, 32'h0, 2'b10, "R10 ns program");
    txn(1, 0, 4, 1, 32'hFFFFFFFF, 2'b10, "R11 secure program");
    txn(1, 0, 1, 1, 32'hFF, 2'b10, "R11 array");
    txn(0, 0, 4, 1, 0, 2'b10, "R10 array kept");
    txn(1, 0, 1, 1, 32'h55, 2'b00, "R7 unknown cmd");
    txn(1, 0, 1, 1, 32'h70, 2'b00, "R7 status cmd");
    txn(0, 5, 2, 0, 0, 2'b00, "R11 ns status when open");
    txn(1, 0, 1, 1, 32'h55, 2'b00, "R7 unknown to array");
    txn(0, 0, 4, 1, 0, 2'b00, "R7 array read");
    // random mix
    for (int i = 0; i < 500; i++) begin
      int sz;
      logic [31:0] wd;
      case ($urandom % 8)
        0, 1: sz = 1;
        2, 3: sz = 2;
        4, 5: sz = 4;
        6: sz = 0;
        default: sz = 3 + ($urandom % 5);
      endcase
      wd = $urandom;
      case ($urandom % 6)
        0: wd[7:0] = 8'hFF;
        1: wd[7:0] = 8'h70;
        2: wd[7:0] = 8'h90;
        3: wd[7:0] = 8'h40;
        default: ;
      endcase
      txn(1'($urandom % 2), int'($urandom % DEPTH), sz, 1'($urandom % 2), wd,
          2'($urandom % 4), "R2 random");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule